// File: doc/BRIEF.md
# Folding-reduction modular multiplier over the secp256k1 prime

This unit multiplies two 256-bit operands and returns the product reduced modulo the prime p = 2^256 − 0x1000003D1. One operation starts with a single-cycle `start` pulse. The unit then copies the operands into its own registers and holds `busy` high. It pulses `done` when the reduced result is ready on `result`. Squaring uses the same operation, with the same value driven on both operand inputs.

Internally, a single 64×64 limb multiplier is reused for sixteen cycles. Each cycle it forms one partial product of limb i of `op_a` and limb j of `op_b`, and adds that product into a 512-bit accumulator at limb position i+j. Limbs are little-endian, so limb 0 holds bits 63:0.

Reduction never divides. It relies on 2^256 ≡ 0x1000003D1 (mod p):

- **First fold:** the upper half of the product is multiplied by the 33-bit constant and added to the lower half.
- **Second fold:** the few bits that remain above bit 255 are folded in the same way. A carry past bit 255 from that pass is folded once more.
- **Final step:** a conditional subtraction of p brings the value into [0, p).

Top module: `fold_modmul`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `result` is all zeros.
- R2: For any two 256-bit operands (limb 0 = bits 63:0), `result` equals op_a·op_b mod p, where p = 2^256 − 0x1000003D1.
- R3: `result` is always fully reduced (less than p). This holds for operands at or above p and for products whose folds carry past bit 255, e.g. (p−1)² gives 1 and (2^256−1)² is reduced.
- R4: `done` rises exactly 19 clock edges after the edge that accepts `start`, whatever the operand values.
- R5: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R6: A `start` pulse while `busy` is high is ignored. Changes on `op_a` and `op_b` after acceptance do not affect the result.
- R7: `result` changes only in the cycle where `done` is high, and holds its value between pulses.
- R8: Driving the same value on both operands yields its square modulo p.
- R9: Zero times any operand gives 0. One times any operand x gives x mod p.
- R10: `busy` goes high in the cycle after `start` is accepted and stays high until `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only when not busy |
| op_a | input | 256 | Multiplicand, little-endian limbs |
| op_b | input | 256 | Multiplier, little-endian limbs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 256 | op_a·op_b mod p, held until the next done |

## Verification
The bench targets the folds' carry paths and the conditional subtraction:

- **(p−1)² and (2^256−1)²:** a design that drops the carry from the second fold, or skips the final subtraction, returns a value at or above p instead of the reduced value.
- **One times p+5:** this must come back as 5, which exposes a missing subtraction of p.
- **Two single-limb operands whose product is exactly 2^256:** this must give 0x1000003D1, so swapped limb order or a wrong placement of partial products changes the answer.
- **A second `start` with new operands in mid-operation:** a design that accepts it, or reads the live operand inputs, produces an extra `done` or a wrong value.
- **Latency:** every result is checked for its exact arrival cycle.

// File: rtl/fold_modmul_pkg.sv
// Package: shared constants and state type of the folding modular multiplier.
// Assumes the field width is 256 bits; FOLD_K = 2^256 - p for the secp256k1 prime.
package fold_modmul_pkg;

    localparam int FOLD_K_W = 33;
    localparam logic [FOLD_K_W-1:0] FOLD_K = 33'h1_0000_03D1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MUL   = 3'd1,
        ST_FOLD1 = 3'd2,
        ST_FOLD2 = 3'd3,
        ST_FINAL = 3'd4
    } mm_state_e;

endpackage

// File: rtl/mm_limb_mul.sv
// Module: mm_limb_mul
// Unsigned W x W combinational multiplier producing a 2W-bit product.
// Assumes the surrounding sequencer registers its output on the same cycle.
module mm_limb_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);

    // Full-width product of one limb pair
    always_comb begin
        p = (2*W)'(x) * (2*W)'(y);
    end

endmodule

// File: rtl/mm_const_fold.sv
// Module: mm_const_fold
// Computes lo + hi * K with no loss of bits. Used for both reduction passes.
// Assumes K fits in K_W bits; the output width covers the largest possible sum.
module mm_const_fold #(
    parameter int LO_W = 256,
    parameter int HI_W = 256,
    parameter int K_W  = 33,
    parameter logic [K_W-1:0] K = '0,
    localparam int OUT_W = ((HI_W + K_W > LO_W) ? (HI_W + K_W) : LO_W) + 1
) (
    input  logic [LO_W-1:0]  lo,
    input  logic [HI_W-1:0]  hi,
    output logic [OUT_W-1:0] sum
);

    logic [HI_W+K_W-1:0] scaled;

    // Scale the high part by the folding constant and add it to the low part
    always_comb begin
        scaled = (HI_W+K_W)'(hi) * (HI_W+K_W)'(K);
        sum    = OUT_W'(lo) + OUT_W'(scaled);
    end

endmodule

// File: rtl/mm_canon.sv
// Module: mm_canon
// Brings a value below 2^FW into [0, p) by one conditional subtraction of p,
// done as an addition of K modulo 2^FW. Assumes K < 2^LIMB_W, so every limb of
// p above limb 0 is all ones; the upper limbs are tested against all-ones.
module mm_canon #(
    parameter int LIMB_W  = 64,
    parameter int N_LIMBS = 4,
    parameter int K_W     = 33,
    parameter logic [K_W-1:0] K = '0,
    localparam int FW = LIMB_W * N_LIMBS
) (
    input  logic [FW-1:0] x,
    output logic [FW-1:0] y
);

    localparam logic [FW-1:0] PRIME = FW'(0) - FW'(K);

    logic [N_LIMBS-1:0] limb_hit;

    // Lowest limb: compare against the low limb of p
    assign limb_hit[0] = (x[LIMB_W-1:0] >= PRIME[LIMB_W-1:0]);

    // Upper limbs: each must be all ones for x to reach p
    for (genvar n = 1; n < N_LIMBS; n++) begin : g_upper
        assign limb_hit[n] = &x[n*LIMB_W +: LIMB_W];
    end

    // Subtract p when x >= p
    always_comb begin
        y = (&limb_hit) ? (x + FW'(K)) : x;
    end

endmodule

// File: rtl/fold_modmul.sv
// Module: fold_modmul (top)
// Multi-cycle a*b mod p for p = 2^256 - FOLD_K.
//   - MUL: N_LIMBS^2 cycles of schoolbook accumulation with one limb multiplier.
//   - FOLD1: the upper half of the product is folded into the lower half.
//   - FOLD2: the remaining upper bits are folded, with any carry folded again.
//   - FINAL: conditional subtraction of p.
// Latency is fixed: done rises N_LIMBS^2 + 3 edges after start is accepted.
// start is ignored while busy. Reset is synchronous, active low.
module fold_modmul
    import fold_modmul_pkg::*;
#(
    parameter int LIMB_W  = 64,
    parameter int N_LIMBS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [LIMB_W*N_LIMBS-1:0]   op_a,
    input  logic [LIMB_W*N_LIMBS-1:0]   op_b,
    output logic                        busy,
    output logic                        done,
    output logic [LIMB_W*N_LIMBS-1:0]   result
);

    localparam int FW      = LIMB_W * N_LIMBS;
    localparam int PW      = 2 * FW;
    localparam int IDX_W   = (N_LIMBS > 1) ? $clog2(N_LIMBS) : 1;
    localparam int CNT_W   = 2 * IDX_W;
    localparam int LAST_PP = N_LIMBS * N_LIMBS - 1;
    localparam int F1_W    = FW + FOLD_K_W + 1;
    localparam int HI2_W   = F1_W - FW;
    localparam int F2_W    = FW + 1;

    mm_state_e          state_q;
    logic [CNT_W-1:0]   pp_idx_q;
    logic [FW-1:0]      a_q, b_q;
    logic [PW-1:0]      acc_q;
    logic [F1_W-1:0]    fold1_q;
    logic [FW-1:0]      fold2_q;
    logic [FW-1:0]      res_q;
    logic               done_q;

    logic [IDX_W-1:0]   idx_i, idx_j;
    logic [IDX_W:0]     pos;
    logic [LIMB_W-1:0]  limb_a, limb_b;
    logic [2*LIMB_W-1:0] pp;
    logic [PW-1:0]      pp_placed;
    logic [F1_W-1:0]    fold1_sum;
    logic [F2_W-1:0]    fold2_sum;
    logic [FW-1:0]      fold2_fixed;
    logic [FW-1:0]      canon_y;

    // Split the partial-product counter into limb indices and their weight
    always_comb begin
        idx_i  = pp_idx_q[CNT_W-1 -: IDX_W];
        idx_j  = pp_idx_q[IDX_W-1:0];
        pos    = {1'b0, idx_i} + {1'b0, idx_j};
        limb_a = a_q[int'(idx_i)*LIMB_W +: LIMB_W];
        limb_b = b_q[int'(idx_j)*LIMB_W +: LIMB_W];
    end

    mm_limb_mul #(.W(LIMB_W)) u_limb_mul (
        .x (limb_a),
        .y (limb_b),
        .p (pp)
    );

    // Place the partial product at limb position i+j
    always_comb begin
        pp_placed = PW'(pp) << (int'(pos) * LIMB_W);
    end

    mm_const_fold #(
        .LO_W (FW),
        .HI_W (FW),
        .K_W  (FOLD_K_W),
        .K    (FOLD_K)
    ) u_fold1 (
        .lo  (acc_q[FW-1:0]),
        .hi  (acc_q[PW-1:FW]),
        .sum (fold1_sum)
    );

    mm_const_fold #(
        .LO_W (FW),
        .HI_W (HI2_W),
        .K_W  (FOLD_K_W),
        .K    (FOLD_K)
    ) u_fold2 (
        .lo  (fold1_q[FW-1:0]),
        .hi  (fold1_q[F1_W-1:FW]),
        .sum (fold2_sum)
    );

    // Fold a carry past bit FW-1 from the second pass once more
    always_comb begin
        fold2_fixed = fold2_sum[FW] ? (fold2_sum[FW-1:0] + FW'(FOLD_K))
                                    : fold2_sum[FW-1:0];
    end

    mm_canon #(
        .LIMB_W  (LIMB_W),
        .N_LIMBS (N_LIMBS),
        .K_W     (FOLD_K_W),
        .K       (FOLD_K)
    ) u_canon (
        .x (fold2_q),
        .y (canon_y)
    );

    // Sequencer: accept, accumulate, fold twice, reduce, publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pp_idx_q <= '0;
            a_q      <= '0;
            b_q      <= '0;
            acc_q    <= '0;
            fold1_q  <= '0;
            fold2_q  <= '0;
            res_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q      <= op_a;
                        b_q      <= op_b;
                        acc_q    <= '0;
                        pp_idx_q <= '0;
                        state_q  <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    acc_q    <= acc_q + pp_placed;
                    pp_idx_q <= pp_idx_q + 1'b1;
                    if (pp_idx_q == CNT_W'(LAST_PP)) begin
                        state_q <= ST_FOLD1;
                    end
                end
                ST_FOLD1: begin
                    fold1_q <= fold1_sum;
                    state_q <= ST_FOLD2;
                end
                ST_FOLD2: begin
                    fold2_q <= fold2_fixed;
                    state_q <= ST_FINAL;
                end
                ST_FINAL: begin
                    res_q   <= canon_y;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs from registered state
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;

endmodule

// File: rtl/fold_modmul_chk.sv
// Module: fold_modmul_chk
// Port-level protocol and range checks for fold_modmul, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module fold_modmul_chk
    import fold_modmul_pkg::*;
#(
    parameter int LIMB_W  = 64,
    parameter int N_LIMBS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      busy,
    input logic                      done,
    input logic [LIMB_W*N_LIMBS-1:0] result
);

    localparam int FW      = LIMB_W * N_LIMBS;
    localparam int LATENCY = N_LIMBS * N_LIMBS + 3;
    localparam logic [FW-1:0] PRIME = FW'(0) - FW'(FOLD_K);

    logic [15:0] busy_cnt;

    // Count the busy cycles of the current operation
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + 1'b1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == 16'(LATENCY))); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < PRIME)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10

endmodule

bind fold_modmul fold_modmul_chk #(
    .LIMB_W  (LIMB_W),
    .N_LIMBS (N_LIMBS)
) u_fold_modmul_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/tb_fold_modmul.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module tb_fold_modmul;

    localparam int LAT = 19;
    localparam logic [255:0] PR = 256'h0 - 256'h1_0000_03D1;

    typedef struct {
        logic [255:0] exp;
        int           issue;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] op_a = '0;
    logic [255:0] op_b = '0;
    logic         busy;
    logic         done;
    logic [255:0] result;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    logic [255:0] last_res = '0;
    exp_t sb[$];

    fold_modmul dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [255:0] ref_mod(input logic [255:0] a, input logic [255:0] b);
        logic [511:0] prod;
        prod = 512'(a) * 512'(b);
        return 256'(prod % 512'(PR));
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected value, pulse start, wait for completion
    task automatic run_op(input string tag, input logic [255:0] a, input logic [255:0] b);
        exp_t e;
        @(negedge clk);
        e.exp = ref_mod(a, b);
        e.issue = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after accept", 256'(busy), 256'(1));
        repeat (LAT) @(negedge clk);
        check("R5 busy low after done", 256'(busy), 256'(0));
    endtask

    // Monitor: pop and compare on done, check hold between pulses
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected done actual=%h expected=none", result);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, result, e.exp);
                    check("R4 latency", 256'(cyc - e.issue), 256'(LAT));
                    last_res = result;
                end
            end else begin
                check("R7 result hold", result, last_res);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] x;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 256'(busy), 256'(0));
        check("R1 done in reset", 256'(done), 256'(0));
        check("R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 256'(busy), 256'(0));
        check("R1 result after reset", result, '0);

        x = rnd256();
        run_op("R9 zero times x", '0, x);
        run_op("R9 x times zero", x, '0);
        run_op("R9 one times x", 256'd1, x);
        run_op("R9 R3 one times p+5", 256'd1, PR + 256'd5);
        run_op("R3 R8 (p-1) squared", PR - 256'd1, PR - 256'd1);
        run_op("R3 R8 all-ones squared", '1, '1);
        run_op("R2 limb order 2^64*2^192", 256'd1 << 64, 256'd1 << 192);
        run_op("R2 top limbs", 256'd1 << 255, 256'd3 << 200);
        for (int n = 0; n < 16; n++) run_op("R2 random", rnd256(), rnd256());
        for (int n = 0; n < 6; n++) begin
            x = rnd256();
            run_op("R8 random square", x, x);
        end

        // R6: a start pulse mid-operation with new operands must be ignored
        begin
            exp_t e;
            x = rnd256();
            @(negedge clk);
            e.exp = ref_mod(x, 256'd7);
            e.issue = cyc + 1;
            e.tag = "R6 ignore start while busy";
            sb.push_back(e);
            op_a = x; op_b = 256'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            op_a = rnd256(); op_b = rnd256(); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            op_a = rnd256();
            repeat (2 * LAT + 4) @(negedge clk);
            check("R6 no pending result", 256'(sb.size()), 256'(0));
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule